// File: doc/BRIEF.md
# Tagged HDLC Transmit FIFO

This block is the staging buffer between a word-wide write port and a byte-serial HDLC transmitter. Software or a bus master stores 32-bit words. Each word carries a four-bit byte-enable mask and three tags: a frame-end mark, a skip-CRC mark and a preamble mark. The frame-end mark is not written as a data bit. It comes from which of two write targets is used. A "frame continue" write leaves the mark clear and a "frame terminate" write sets it. The transmitter takes the stored bytes one request at a time. It gets each byte together with a frame-start and a frame-end indication, so it knows when to send an opening flag and when to append a CRC and a closing flag.

Frame boundaries are found only at the output end. The first byte after an idle period or after a completed frame begins a new frame. The last enabled byte of a word written through the terminate target ends the frame. A status flag tells the writer that there is room. A mode input raises the threshold of this flag from one free word to a block of free words. An abort input and a transmit-reset input empty the buffer. The active-low reset does the same. After any of these, the buffer refuses traffic for a short fixed recovery window.

Top module: `htx_tag_fifo`

## Requirements
- R1: After the active-low reset is released, `avail_o`, `rd_vld_o`, `overflow_o` and `underrun_o` are 0. `avail_o` stays 0 for the first 3 rising edges and rises on the 3rd edge when `mode_wide_i` is 0.
- R2: Bytes of a stored word are delivered lowest lane first (lane k is `wr_data_i[8k+7:8k]`, and `wr_be_i[k]` enables it). Words come out in write order. Bytes of a word written with `wr_term_i` = 0 never carry `rd_eof_o`.
- R3: A word written with `wr_term_i` = 1 marks its highest enabled byte with `rd_eof_o` = 1, and only that byte.
- R4: Lanes whose enable bit is 0 are skipped and never delivered. A write with `wr_be_i` = 0 stores nothing and does not set the overflow flag.
- R5: `rd_sof_o` = 1 accompanies the first byte delivered after reset, abort, transmit-reset or a byte that carried `rd_eof_o`, and is 0 otherwise. `rd_pre_o` equals the preamble tag of the word when `rd_sof_o` = 1, and is 0 otherwise.
- R6: `rd_nocrc_o` equals the skip-CRC tag of the word on a byte with `rd_eof_o` = 1, and is 0 otherwise.
- R7: With `mode_wide_i` = 0 and no clear window, `avail_o` = 1 exactly when fewer than 8 words are held.
- R8: With `mode_wide_i` = 1 and no clear window, `avail_o` = 1 exactly when at least 4 of the 8 word slots are free.
- R9: A non-empty write that arrives while 8 words are held is dropped and sets `overflow_o`. The flag stays 1 until a clear.
- R10: A read request while no word is held delivers no byte and sets `underrun_o`. The flag stays 1 until a clear.
- R11: `abort_i` = 1 or `txrst_i` = 1 at an edge discards all words and tags, clears both sticky flags, cancels any partly read word and ends the current frame. During that cycle and the 3 cycles after it, `avail_o` is 0 and writes and read requests are ignored.
- R12: A byte accepted on a rising edge is presented with `rd_vld_o` = 1 for exactly the following cycle. At most one byte is delivered per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Transmit abort: empties the buffer |
| txrst_i | input | 1 | Transmit reset: empties the buffer |
| mode_wide_i | input | 1 | 0: room flag needs one free word; 1: needs four |
| wr_en_i | input | 1 | Write strobe |
| wr_term_i | input | 1 | Write target: 0 frame continue, 1 frame terminate |
| wr_be_i | input | 4 | Byte enables, bit k for lane k |
| wr_data_i | input | 32 | Write data, lane k at bits 8k+7:8k |
| wr_nocrc_i | input | 1 | Skip-CRC tag for the written word |
| wr_pre_i | input | 1 | Preamble tag for the written word |
| avail_o | output | 1 | Room flag for the writer |
| overflow_o | output | 1 | Sticky: a write was dropped while full |
| rd_req_i | input | 1 | Transmitter requests the next byte |
| rd_vld_o | output | 1 | Byte present on the read outputs this cycle |
| rd_byte_o | output | 8 | Delivered byte |
| rd_sof_o | output | 1 | Byte opens a frame |
| rd_eof_o | output | 1 | Byte closes a frame |
| rd_nocrc_o | output | 1 | Closing byte's frame skips the CRC |
| rd_pre_o | output | 1 | Opening byte's frame wants a preamble |
| underrun_o | output | 1 | Sticky: a request found the buffer empty |

## Verification
A directed pass writes full words through both targets and reads them back. This separates lane order and frame-end placement from a byte-count mistake. Sparse masks such as 1010 and an all-zero mask check that lane skipping works and that an empty write is not stored. The buffer is then filled past eight words in both threshold modes, which places the room flag and the drop decision at their exact fill levels. Long random runs follow, with mixed reads, writes, masks, mode changes and occasional abort or transmit-reset pulses. These hit clears that land in the middle of a frame or a word, and reads and writes that meet in the same cycle at the full and empty edges.

// File: rtl/htxf_pkg.sv
package htxf_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int LIDX_W = $clog2(LANES);

  typedef logic [LANES-1:0]  lmask_t;
  typedef logic [LIDX_W-1:0] lidx_t;

  // One stored word with its side tags
  typedef struct packed {
    lmask_t              vmask;
    logic                last;
    logic                nocrc;
    logic                pre;
    logic [WORD_W-1:0]   data;
  } hword_t;

  // Index of the lowest set bit (0 when none)
  function automatic lidx_t first_lane(input lmask_t m);
    lidx_t r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (m[i]) r = lidx_t'(i);
    end
    return r;
  endfunction

  function automatic lmask_t lane_bit(input lidx_t i);
    return lmask_t'(1) << i;
  endfunction

  function automatic logic [LANE_W-1:0] lane_of(input logic [WORD_W-1:0] d, input lidx_t i);
    return d[int'(i)*LANE_W +: LANE_W];
  endfunction

  // Room test for the writer status flag
  function automatic logic room_ok(input int free_n, input logic wide, input int wide_thr);
    return wide ? (free_n >= wide_thr) : (free_n >= 1);
  endfunction

endpackage

// File: rtl/htxf_clrseq.sv
module htxf_clrseq #(
  parameter int CLR_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_i,
  input  logic txrst_i,
  output logic clr_now,
  output logic blocked
);
  localparam int BW = $clog2(CLR_CYCLES + 1);

  logic [BW-1:0] hold_q;

  assign clr_now = abort_i | txrst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= BW'(CLR_CYCLES);
    end else if (clr_now) begin
      hold_q <= BW'(CLR_CYCLES);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign blocked = clr_now | (hold_q != '0);

endmodule

// File: rtl/htxf_store.sv
module htxf_store
  import htxf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  hword_t        push_word,
  input  logic          pop,
  output hword_t        head,
  output logic [CW-1:0] count,
  output logic          empty
);

  hword_t        slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[e] <= '0;
      end else if (clr) begin
        slot_q[e] <= '0;
      end else if (push && wr_q == PW'(e)) begin
        slot_q[e] <= push_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = slot_q[rd_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/htxf_wrside.sv
module htxf_wrside
  import htxf_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int AVAIL_WIDE = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              blocked,
  input  logic              wr_en,
  input  logic              wr_term,
  input  lmask_t            wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_nocrc,
  input  logic              wr_pre,
  input  logic              mode_wide,
  input  logic [CW-1:0]     count,
  output logic              push,
  output hword_t            push_word,
  output logic              avail,
  output logic              overflow
);

  logic attempt, full, drop;
  int   free_n;

  assign attempt = wr_en && !blocked && (wr_be != '0);
  assign full    = (count == CW'(DEPTH));
  assign push    = attempt && !full;
  assign drop    = attempt && full;

  // The write target decides the frame-end tag
  always_comb begin
    push_word.vmask = wr_be;
    push_word.last  = wr_term;
    push_word.nocrc = wr_nocrc;
    push_word.pre   = wr_pre;
    push_word.data  = wr_data;
  end

  assign free_n = DEPTH - int'(count);
  assign avail  = !blocked && room_ok(free_n, mode_wide, AVAIL_WIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow <= 1'b0;
    end else if (clr) begin
      overflow <= 1'b0;
    end else if (drop) begin
      overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/htxf_reader.sv
module htxf_reader
  import htxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              blocked,
  input  logic              rd_req,
  input  hword_t            head,
  input  logic              empty,
  output logic              take,
  output logic              pop,
  output lmask_t            taken,
  output logic              rd_vld,
  output logic [LANE_W-1:0] rd_byte,
  output logic              rd_sof,
  output logic              rd_eof,
  output logic              rd_nocrc,
  output logic              rd_pre,
  output logic              underrun
);

  lmask_t taken_q, rem, rest;
  lidx_t  lane;
  logic   last_lane, frame_end, starve, in_frame_q;

  assign rem       = head.vmask & ~taken_q;
  assign lane      = first_lane(rem);
  assign rest      = rem & ~lane_bit(lane);
  assign last_lane = (rest == '0);
  assign frame_end = last_lane && head.last;

  assign take   = rd_req && !blocked && !empty;
  assign starve = rd_req && !blocked && empty;
  assign pop    = take && last_lane;
  assign taken  = taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q    <= '0;
      in_frame_q <= 1'b0;
      rd_vld     <= 1'b0;
      rd_byte    <= '0;
      rd_sof     <= 1'b0;
      rd_eof     <= 1'b0;
      rd_nocrc   <= 1'b0;
      rd_pre     <= 1'b0;
      underrun   <= 1'b0;
    end else if (clr) begin
      taken_q    <= '0;
      in_frame_q <= 1'b0;
      rd_vld     <= 1'b0;
      rd_sof     <= 1'b0;
      rd_eof     <= 1'b0;
      rd_nocrc   <= 1'b0;
      rd_pre     <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      rd_vld   <= take;
      rd_sof   <= take && !in_frame_q;
      rd_eof   <= take && frame_end;
      rd_nocrc <= take && frame_end && head.nocrc;
      rd_pre   <= take && !in_frame_q && head.pre;
      if (take) begin
        rd_byte    <= lane_of(head.data, lane);
        in_frame_q <= !frame_end;
        taken_q    <= pop ? '0 : (taken_q | lane_bit(lane));
      end
      if (starve) underrun <= 1'b1;
    end
  end

endmodule

// File: rtl/htx_tag_fifo.sv
module htx_tag_fifo
  import htxf_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int AVAIL_WIDE = 4,
  parameter int CLR_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort_i,
  input  logic        txrst_i,
  input  logic        mode_wide_i,
  input  logic        wr_en_i,
  input  logic        wr_term_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  input  logic        wr_nocrc_i,
  input  logic        wr_pre_i,
  output logic        avail_o,
  output logic        overflow_o,
  input  logic        rd_req_i,
  output logic        rd_vld_o,
  output logic [7:0]  rd_byte_o,
  output logic        rd_sof_o,
  output logic        rd_eof_o,
  output logic        rd_nocrc_o,
  output logic        rd_pre_o,
  output logic        underrun_o
);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events (also observed by the checker)
  logic          clr_now, blocked, push, pop, take, empty;
  logic [CW-1:0] fill_cnt;
  hword_t        push_word, head;
  lmask_t        taken_mask, head_vmask;

  assign head_vmask = head.vmask;

  htxf_clrseq #(.CLR_CYCLES(CLR_CYCLES)) u_clrseq (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .txrst_i(txrst_i),
    .clr_now(clr_now), .blocked(blocked)
  );

  htxf_wrside #(.DEPTH(DEPTH), .AVAIL_WIDE(AVAIL_WIDE)) u_wrside (
    .clk(clk), .rst_n(rst_n), .clr(clr_now), .blocked(blocked),
    .wr_en(wr_en_i), .wr_term(wr_term_i), .wr_be(wr_be_i), .wr_data(wr_data_i),
    .wr_nocrc(wr_nocrc_i), .wr_pre(wr_pre_i), .mode_wide(mode_wide_i),
    .count(fill_cnt), .push(push), .push_word(push_word),
    .avail(avail_o), .overflow(overflow_o)
  );

  htxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr_now), .push(push), .push_word(push_word),
    .pop(pop), .head(head), .count(fill_cnt), .empty(empty)
  );

  htxf_reader u_reader (
    .clk(clk), .rst_n(rst_n), .clr(clr_now), .blocked(blocked), .rd_req(rd_req_i),
    .head(head), .empty(empty), .take(take), .pop(pop), .taken(taken_mask),
    .rd_vld(rd_vld_o), .rd_byte(rd_byte_o), .rd_sof(rd_sof_o), .rd_eof(rd_eof_o),
    .rd_nocrc(rd_nocrc_o), .rd_pre(rd_pre_o), .underrun(underrun_o)
  );

endmodule

// File: rtl/htxf_checker.sv
module htxf_checker #(
  parameter int DEPTH      = 8,
  parameter int AVAIL_WIDE = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_now,
  input logic          blocked,
  input logic          mode_wide,
  input logic          avail,
  input logic [CW-1:0] count,
  input logic          overflow,
  input logic          underrun,
  input logic          rd_req,
  input logic          rd_vld,
  input logic          take,
  input logic          pop,
  input logic          push,
  input logic          empty,
  input logic [3:0]    taken,
  input logic [3:0]    head_vmask
);

  assert_avail_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !avail);

  assert_no_push_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !push);

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (count == '0 && !overflow && !underrun && !rd_vld));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_now) |=> overflow);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr_now) |=> underrun);

  assert_narrow_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && !mode_wide) |-> (int'(count) < DEPTH));

  assert_wide_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && mode_wide) |-> (int'(count) <= DEPTH - AVAIL_WIDE));

  assert_byte_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_req));

  assert_pop_needs_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> take);

  assert_taken_inside_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (((taken & ~head_vmask) == 4'b0) && (taken != head_vmask)));

endmodule

bind htx_tag_fifo htxf_checker #(.DEPTH(DEPTH), .AVAIL_WIDE(AVAIL_WIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_now(clr_now), .blocked(blocked),
  .mode_wide(mode_wide_i), .avail(avail_o), .count(fill_cnt),
  .overflow(overflow_o), .underrun(underrun_o), .rd_req(rd_req_i),
  .rd_vld(rd_vld_o), .take(take), .pop(pop), .push(push), .empty(empty),
  .taken(taken_mask), .head_vmask(head_vmask)
);

// File: tb/htx_tag_fifo_bench.sv
`timescale 1ns/1ps
module htx_tag_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort_i = 0, txrst_i = 0, mode_wide_i = 0;
  logic        wr_en_i = 0, wr_term_i = 0, wr_nocrc_i = 0, wr_pre_i = 0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_req_i = 0;
  logic        avail_o, overflow_o, rd_vld_o, rd_sof_o, rd_eof_o, rd_nocrc_o, rd_pre_o, underrun_o;
  logic [7:0]  rd_byte_o;

  htx_tag_fifo u_htx_tag_fifo (.*);

  always #10 clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;

  // Bench model of the buffer
  bit [3:0]  q_be[$];
  bit [31:0] q_d[$];
  bit        q_term[$], q_nc[$], q_pr[$];
  bit [3:0]  m_taken = '0;
  bit        m_inframe = 0, m_ovf = 0, m_unr = 0;
  int        m_hold = 3;
  bit        e_vld = 0, e_sof = 0, e_eof = 0, e_nc = 0, e_pr = 0;
  bit [7:0]  e_byte = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int low_lane(input bit [3:0] m);
    int r = -1;
    for (int i = 0; i < 4; i++) if (m[i] && r < 0) r = i;
    return r;
  endfunction

  function automatic bit room(input int held, input bit wide);
    if (wide) return (8 - held) >= 4;
    return held < 8;
  endfunction

  task automatic model_clear();
    q_be.delete(); q_d.delete(); q_term.delete(); q_nc.delete(); q_pr.delete();
    m_taken = '0; m_inframe = 0; m_ovf = 0; m_unr = 0; m_hold = 3;
  endtask

  task automatic step(input bit we, input bit term, input bit [3:0] be, input bit [31:0] d,
                      input bit nc, input bit pr, input bit rd, input bit ab, input bit tr,
                      input bit wide);
    bit blk, exp_av;
    int held;
    wr_en_i = we; wr_term_i = term; wr_be_i = be; wr_data_i = d; wr_nocrc_i = nc;
    wr_pre_i = pr; rd_req_i = rd; abort_i = ab; txrst_i = tr; mode_wide_i = wide;
    #1;
    blk    = ab || tr || (m_hold != 0);
    exp_av = !blk && room(q_be.size(), wide);
    check(avail_o === exp_av, blk ? "R11" : (wide ? "R8" : "R7"), avail_o, exp_av);
    e_vld = 0; e_sof = 0; e_eof = 0; e_nc = 0; e_pr = 0;
    if (ab || tr) begin
      model_clear();
    end else if (m_hold != 0) begin
      m_hold--;
    end else begin
      held = q_be.size();
      if (rd) begin
        if (held == 0) m_unr = 1;
        else begin
          bit [3:0] rem, rest;
          int ln;
          rem   = q_be[0] & ~m_taken;
          ln    = low_lane(rem);
          rest  = rem & ~(4'b1 << ln);
          e_vld = 1;
          e_byte = q_d[0][ln*8 +: 8];
          e_sof = !m_inframe;
          e_eof = (rest == 0) && q_term[0];
          e_nc  = e_eof && q_nc[0];
          e_pr  = !m_inframe && q_pr[0];
          m_inframe = !e_eof;
          if (rest == 0) begin
            void'(q_be.pop_front()); void'(q_d.pop_front()); void'(q_term.pop_front());
            void'(q_nc.pop_front()); void'(q_pr.pop_front());
            m_taken = '0;
          end else m_taken |= (4'b1 << ln);
        end
      end
      if (we && be != 0) begin
        if (held == 8) m_ovf = 1;
        else begin
          q_be.push_back(be); q_d.push_back(d); q_term.push_back(term);
          q_nc.push_back(nc); q_pr.push_back(pr);
        end
      end
    end
    @(negedge clk);
    check(rd_vld_o === e_vld, "R12", rd_vld_o, e_vld);
    if (e_vld) begin
      check(rd_byte_o === e_byte, "R2/R4", rd_byte_o, e_byte);
      check(rd_sof_o === e_sof, "R5 sof", rd_sof_o, e_sof);
      check(rd_pre_o === e_pr, "R5 pre", rd_pre_o, e_pr);
      check(rd_eof_o === e_eof, "R3", rd_eof_o, e_eof);
      check(rd_nocrc_o === e_nc, "R6", rd_nocrc_o, e_nc);
    end
    check(overflow_o === m_ovf, "R9", overflow_o, m_ovf);
    check(underrun_o === m_unr, "R10", underrun_o, m_unr);
  endtask

  task automatic wr(input bit term, input bit [3:0] be, input bit [31:0] d, input bit nc, input bit pr, input bit wide);
    step(1, term, be, d, nc, pr, 0, 0, 0, wide);
  endtask

  task automatic rd(input int n, input bit wide);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 0, wide);
  endtask

  task automatic idle(input int n, input bit wide);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, wide);
  endtask

  initial begin
    bit wide;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: state right after reset release
    check(avail_o === 1'b0, "R1 avail", avail_o, 0);
    check(rd_vld_o === 1'b0, "R1 vld", rd_vld_o, 0);
    check(overflow_o === 1'b0, "R1 ovf", overflow_o, 0);
    check(underrun_o === 1'b0, "R1 unr", underrun_o, 0);
    idle(5, 0);  // R1: room flag rises after the recovery window
    // R2/R3/R5/R6: one frame over two words
    wr(0, 4'hF, 32'h44332211, 0, 1, 0);
    wr(1, 4'hF, 32'h88776655, 1, 0, 0);
    rd(8, 0);
    // R4: sparse lanes, then an empty-mask write, then a starved read
    wr(1, 4'b1010, 32'hDDCCBBAA, 0, 0, 0);
    wr(1, 4'b0000, 32'h12345678, 0, 0, 0);
    rd(3, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);  // transmit reset clears R10 flag
    idle(4, 0);
    // R7/R9: fill past eight words in narrow mode
    for (int i = 0; i < 9; i++) wr(i[0], 4'hF, 32'h01010101 * (i + 1), 0, 0, 0);
    // R8: wide mode while draining
    rd(20, 1);
    for (int i = 0; i < 6; i++) wr(0, 4'h3, 32'hA0B0C0D0 + i, 0, 1, 1);
    rd(3, 1);
    // R11: abort in the middle of a word
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 1);
    idle(4, 1);
    // Random traffic
    wide = 0;
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom % 1000;
      if (n % 700 == 699) wide = ~wide;
      step(($urandom % 100) < 45, ($urandom % 4) == 0, 4'($urandom), $urandom,
           ($urandom % 2) == 1, ($urandom % 3) == 0, ($urandom % 100) < 50,
           r < 4, r >= 996, wide);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule